// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block is the write-only serial front end of a display controller. The serial path is enabled only when three conditions hold: an active-low select is low, an active-high select is high, and the bus-mode input asks for serial operation. While the path is enabled, the block shifts in one bit of serial data on each rising serial clock edge, most significant bit first. On every eighth rising edge it turns the eight bits into a parallel byte. The byte carries a tag taken from the data/command line at that same edge: display data when the line is high, a command when it is low.

All serial inputs are asynchronous to the system clock. They pass through a synchronizer chain, and serial clock edges are detected in the system clock domain. Each completed byte is presented with a valid strobe that lasts one system cycle. The bit counter wraps, so bytes can follow one another without a deselect in between. When the path is disabled, the shift register and the bit counter are cleared, and any partial byte is dropped without a strobe.

The control is a two-state machine. `ST_OFF` means the path is disabled. `ST_RECV` means bits are being received. The transition `enable` (OFF to RECV) fires when the synchronized select and mode condition becomes true. The transition `drop` (RECV to OFF) fires when that condition goes false. While the block stays in `ST_RECV`, a rising edge does one of two things: a `shift` step stores a bit, and a `complete` step on the eighth bit emits the byte and wraps the counter.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, byte_out is 0x00, byte_is_data is 0 and byte_valid is 0.
- R2: Bytes are received only while sel_n=0, sel=1 and par_mode=0. Any other combination produces no strobe.
- R3: Bits are taken from sdata on rising sclk edges, the first bit into byte_out[7] and the eighth into byte_out[0].
- R4: After the eighth rising edge, byte_out shows the assembled byte and byte_valid pulses. byte_out and byte_is_data do not change except in a cycle where byte_valid is high.
- R5: byte_is_data equals the level of dc_sel at the eighth rising edge (1 = display data, 0 = command). Its level at the other seven edges has no effect.
- R6: Disabling the path in the middle of a byte discards the partial bits. The next enabled period starts again at bit 7, and the dropped byte never strobes.
- R7: Consecutive bytes without a deselect between them are each received correctly, because the bit counter wraps after eight bits.
- R8: byte_valid is high for exactly one system clock cycle per completed byte.
- R9: Changes of sdata while sclk is high, and falling sclk edges, do not affect the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| par_mode | input | 1 | Bus mode; 0 selects serial operation |
| sdata | input | 1 | Serial data |
| sclk | input | 1 | Serial clock |
| dc_sel | input | 1 | Data/command tag, 1 = display data |
| byte_out | output | 8 | Last received byte |
| byte_is_data | output | 1 | Tag of the last received byte |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |

## Verification
Some properties are checked on every cycle by the assertions. The strobe never lasts two cycles. The disabled state never produces a strobe. The bit counter is zero after a cycle with the path disabled and again after each completed byte. The outputs hold steady between strobes.

Other behaviour shows only in the bench's scenarios. These are the bit order, the tag taken at the eighth edge rather than earlier, the dropping of partial bytes for each of the three ways to disable the path, and insensitivity to data changes while the serial clock is high. The bench checks them by sending known bytes and comparing the logged strobes.

// File: rtl/scr_pkg.sv
package scr_pkg;
    typedef enum logic {
        ST_OFF  = 1'b0,
        ST_RECV = 1'b1
    } rx_state_t;

    // positions inside the synchronized input vector
    localparam int IN_SCLK = 0;
    localparam int IN_SD   = 1;
    localparam int IN_DC   = 2;
    localparam int IN_SELH = 3;
    localparam int IN_SELL = 4;
    localparam int IN_MODE = 5;
    localparam int IN_W    = 6;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/scr_edge.sv
module scr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/scr_fsm.sv
module scr_fsm
    import scr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              rise_i,
    input  logic              sd_i,
    input  logic              dc_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              is_data_o,
    output logic              vld_o
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] sh_next;

    assign sh_next = {sh_q[BYTE_W-2:0], sd_i};

    // next state: enable / drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (active_i)  state_d = ST_RECV;
            ST_RECV: if (!active_i) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // datapath and outputs: shift / complete
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sh_q      <= '0;
            byte_o    <= '0;
            is_data_o <= 1'b0;
            vld_o     <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            unique case (state_q)
                ST_OFF: begin
                    cnt_q <= '0;
                    sh_q  <= '0;
                end
                ST_RECV: begin
                    if (!active_i) begin
                        cnt_q <= '0;
                        sh_q  <= '0;
                    end else if (rise_i) begin
                        if (cnt_q == LAST) begin
                            byte_o    <= sh_next;
                            is_data_o <= dc_i;
                            vld_o     <= 1'b1;
                            cnt_q     <= '0;
                            sh_q      <= '0;
                        end else begin
                            sh_q  <= sh_next;
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    cnt_q <= '0;
                    sh_q  <= '0;
                end
            endcase
        end
    end

    // R8: strobe lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);

    // R2: the disabled state never yields a byte
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> !vld_o);

    // R6: partial byte dropped when the path is disabled
    a_r6_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (cnt_q == '0));

    // R7: counter wraps on completion
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (cnt_q == '0));

    // R4: outputs hold between strobes
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> ($stable(byte_o) && $stable(is_data_o)));
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import scr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              par_mode,
    input  logic              sdata,
    input  logic              sclk,
    input  logic              dc_sel,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_is_data,
    output logic              byte_valid
);
    logic [IN_W-1:0] raw_in;
    logic [IN_W-1:0] syn_in;
    logic            sclk_rise;
    logic            path_on;

    always_comb begin
        raw_in          = '0;
        raw_in[IN_SCLK] = sclk;
        raw_in[IN_SD]   = sdata;
        raw_in[IN_DC]   = dc_sel;
        raw_in[IN_SELH] = sel;
        raw_in[IN_SELL] = ~sel_n;   // stored inverted so reset means deselected
        raw_in[IN_MODE] = par_mode;
    end

    scr_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    scr_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (syn_in[IN_SCLK]),
        .rise_o (sclk_rise)
    );

    assign path_on = syn_in[IN_SELL] & syn_in[IN_SELH] & ~syn_in[IN_MODE];

    scr_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (path_on),
        .rise_i    (sclk_rise),
        .sd_i      (syn_in[IN_SD]),
        .dc_i      (syn_in[IN_DC]),
        .byte_o    (byte_out),
        .is_data_o (byte_is_data),
        .vld_o     (byte_valid)
    );
endmodule

// File: tb/serial_cmd_rx_tb.sv
module serial_cmd_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;   // system cycles per serial half period
    localparam int NVEC       = 6;
    // {tag, byte}
    localparam logic [8:0] VEC [NVEC] = '{
        9'h1_A5, 9'h0_3C, 9'h1_FF, 9'h0_00, 9'h1_81, 9'h0_5E
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1, sel = 1'b0, par_mode = 1'b0;
    logic       sdata = 1'b0, sclk = 1'b0, dc_sel = 1'b0;
    logic [7:0] byte_out;
    logic       byte_is_data, byte_valid;

    int errors = 0;
    int checks = 0;
    logic [7:0] lg_b [64];
    logic       lg_f [64];
    int         lg_n = 0;
    int         wide = 0;
    logic       prev_v = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cmd_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .par_mode(par_mode),
        .sdata(sdata), .sclk(sclk), .dc_sel(dc_sel),
        .byte_out(byte_out), .byte_is_data(byte_is_data), .byte_valid(byte_valid)
    );

    always @(negedge clk) begin
        if (byte_valid && lg_n < 64) begin
            lg_b[lg_n] = byte_out;
            lg_f[lg_n] = byte_is_data;
            lg_n       = lg_n + 1;
        end
        if (byte_valid && prev_v) wide = wide + 1;
        prev_v = byte_valid;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // nbits bits, MSB first; dc_last applies at the final edge of a full byte
    task automatic send(input logic [7:0] b, input int nbits, input bit dc_early,
                        input bit dc_last, input bit glitch);
        for (int i = 0; i < nbits; i++) begin
            sdata  = b[7-i];
            dc_sel = (i == 7) ? dc_last : dc_early;
            idle(HALF);
            sclk = 1'b1;
            idle(1);
            if (glitch) sdata = ~b[7-i];
            idle(HALF - 1);
            sclk = 1'b0;
        end
        idle(HALF);
    endtask

    task automatic enable_path();
        sel_n = 1'b0; sel = 1'b1; par_mode = 1'b0;
        idle(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        idle(3);
        // R1: reset state
        chk(byte_out == 8'h00, "R1 byte", byte_out, 0);
        chk(byte_is_data == 1'b0, "R1 tag", byte_is_data, 0);
        chk(byte_valid == 1'b0, "R1 valid", byte_valid, 0);
        rst_n = 1'b1;
        idle(4);

        // R3 R4 R5 R7: table of back-to-back bytes, no deselect between
        enable_path();
        base = lg_n;
        for (int v = 0; v < NVEC; v++)
            send(VEC[v][7:0], 8, VEC[v][8], VEC[v][8], 1'b0);
        idle(8);
        chk(lg_n - base == NVEC, "R7 count", lg_n - base, NVEC);
        for (int v = 0; v < NVEC; v++) begin
            chk(lg_b[base+v] == VEC[v][7:0], "R3 byte", lg_b[base+v], VEC[v][7:0]);
            chk(lg_f[base+v] == VEC[v][8], "R5 tag", lg_f[base+v], VEC[v][8]);
        end
        chk(byte_out == VEC[NVEC-1][7:0], "R4 hold", byte_out, VEC[NVEC-1][7:0]);

        // R5: tag taken only at the eighth edge
        base = lg_n;
        send(8'h69, 8, 1'b1, 1'b0, 1'b0);
        send(8'h96, 8, 1'b0, 1'b1, 1'b0);
        idle(8);
        chk(lg_n - base == 2, "R5 count", lg_n - base, 2);
        chk(lg_f[base] == 1'b0, "R5 late-low", lg_f[base], 0);
        chk(lg_f[base+1] == 1'b1, "R5 late-high", lg_f[base+1], 1);

        // R9: data changes while sclk high are ignored
        base = lg_n;
        send(8'hC3, 8, 1'b1, 1'b1, 1'b1);
        idle(8);
        chk(lg_n - base == 1, "R9 count", lg_n - base, 1);
        chk(lg_b[base] == 8'hC3, "R9 byte", lg_b[base], 8'hC3);

        // R6: abort by each of the three disabling inputs
        for (int k = 0; k < 3; k++) begin
            base = lg_n;
            send(8'hF0, 3, 1'b1, 1'b1, 1'b0);
            if (k == 0) sel_n = 1'b1;
            else if (k == 1) sel = 1'b0;
            else par_mode = 1'b1;
            idle(10);
            chk(lg_n == base, "R6 no strobe", lg_n - base, 0);
            enable_path();
            send(8'h5A, 8, 1'b0, 1'b0, 1'b0);
            idle(8);
            chk(lg_n - base == 1, "R6 restart count", lg_n - base, 1);
            chk(lg_b[base] == 8'h5A, "R6 restart byte", lg_b[base], 8'h5A);
        end

        // R2: full bytes while disabled are ignored
        base = lg_n;
        par_mode = 1'b1; idle(6);
        send(8'h77, 8, 1'b1, 1'b1, 1'b0);
        par_mode = 1'b0; sel_n = 1'b1; idle(6);
        send(8'h11, 8, 1'b1, 1'b1, 1'b0);
        sel_n = 1'b0; sel = 1'b0; idle(6);
        send(8'h22, 8, 1'b1, 1'b1, 1'b0);
        idle(8);
        chk(lg_n == base, "R2 no bytes", lg_n - base, 0);
        chk(byte_out == 8'h5A, "R2 output held", byte_out, 8'h5A);

        // R8: strobe width over the whole run
        chk(wide == 0, "R8 pulse width", wide, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule